// File: doc/BRIEF.md
# Multicart ROM Bank Mapper

This block sits on the cartridge side of an 8-bit console. It turns CPU writes in the upper half of the 16-bit address space into bank selections for a multi-game cartridge. Three internal registers are loaded from the write data: two bank-select bytes and a four-bit mode word. From these registers the block forms extended ROM addresses for the program and character buses, and it picks the nametable mirroring.

The program space has two 16 KB windows. The low window is switchable. The high window is either pinned to the last bank of the current game group or, in a wide mode, joined to the low window as an aligned even/odd pair. A two-bit game-group field moves the program banks in steps of 8 and the pattern banks in steps of 32. Each of the two 4 KB pattern windows takes its bank from the top five bits of one bank-select byte. The low bits of that same byte also carry the program bank.

The bank outputs are combinational from the registers, so a write takes effect on the access after the clock edge that stores it.

Top module: `multicart_bank_mapper`

## Requirements
- R1: A write (cpuWrite high at a rising clock edge with cpuAddr[15]=1) is steered by cpuAddr[14:13]. Value 01 (0xA000–0xBFFF) loads all eight bits of bank register A. Value 10 (0xC000–0xDFFF) loads all eight bits of bank register B. Value 11 (0xE000–0xFFFF) loads the mode register.
- R2: A write with cpuAddr[15:13]=100 (0x8000–0x9FFF) changes none of the outputs. So does any strobe while cpuAddr[15]=0.
- R3: The mode register keeps only data bits [3:0]. Bits [1:0] are the game group, bit 2 is the mirroring select, and bit 3 is the wide-PRG select. Data bits [7:4] are discarded.
- R4: With mode bit 3 = 0, the 0x8000 window uses PRG bank {group, A[2:0]} and the 0xC000 window uses PRG bank {group, 3'b111}.
- R5: With mode bit 3 = 1, the 0x8000 window uses PRG bank {group, A[2:1], 0} and the 0xC000 window uses PRG bank {group, A[2:1], 1}. Bit A[0] has no effect.
- R6: The game group forms the top two bits of both bank numbers. It adds group×8 to the 16 KB PRG bank and group×32 to the 4 KB CHR bank.
- R7: The CHR window at ppuAddr[12]=0 uses bank {group, A[7:3]}. The window at ppuAddr[12]=1 uses bank {group, B[7:3]}.
- R8: ciramA10 follows ppuAddr[10] when mode bit 2 is 0 (vertical mirroring) and ppuAddr[11] when it is 1 (horizontal mirroring).
- R9: A synchronous reset clears all three registers. The 0x8000 window then maps to bank 0, the 0xC000 window to bank 7, both CHR windows to bank 0, and mirroring is vertical.
- R10: prgRomAddr is {prgBank, cpuAddr[13:0]}, where cpuAddr[14] picks the window. chrRomAddr is {chrBank, ppuAddr[11:0]}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpuAddr | input | 16 | CPU address bus |
| cpuData | input | 8 | CPU write data |
| cpuWrite | input | 1 | CPU write strobe |
| ppuAddr | input | 14 | PPU address bus |
| prgRomAddr | output | 19 | Program ROM address |
| chrRomAddr | output | 19 | Character ROM address |
| ciramA10 | output | 1 | Nametable RAM A10 select |

## Verification
Every cycle, the assertions check the write decode into each register, the discarded upper mode bits, and that registers hold through writes to the dead region. They also check that the game group appears at the top of both ROM addresses, the fixed and paired upper-window rules, and the reset values. The mirroring select and the full bank arithmetic across mixed sequences of random writes can only be shown by the bench. It compares every output port against a reference model, probing random CPU and PPU addresses after each write.

// File: rtl/mcmap_pkg.sv
package mcmap_pkg;
  typedef struct packed {
    logic loadBankA;
    logic loadBankB;
    logic loadMode;
  } regStrobe_t;
endpackage

// File: rtl/mcmap_ctrl.sv
module mcmap_ctrl
  import mcmap_pkg::*;
(
  input  logic [15:0] cpuAddr,
  input  logic        cpuWrite,
  output regStrobe_t  strobe
);
  logic inWindow;
  assign inWindow = cpuWrite && cpuAddr[15];

  always_comb begin
    strobe = '0;
    if (inWindow) begin
      unique case (cpuAddr[14:13])
        2'b01:   strobe.loadBankA = 1'b1;
        2'b10:   strobe.loadBankB = 1'b1;
        2'b11:   strobe.loadMode  = 1'b1;
        default: strobe = '0;
      endcase
    end
  end
endmodule

// File: rtl/mcmap_datapath.sv
module mcmap_datapath
  import mcmap_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OUTER_W     = 2,
  parameter int PRG_INNER_W = 3,
  parameter int PRG_WIN_AW  = 14,
  parameter int CHR_WIN_AW  = 12,
  localparam int MODE_W      = OUTER_W + 2,
  localparam int CHR_INNER_W = DATA_W - PRG_INNER_W,
  localparam int PRG_BANK_W  = OUTER_W + PRG_INNER_W,
  localparam int CHR_BANK_W  = OUTER_W + CHR_INNER_W,
  localparam int PRG_AW      = PRG_BANK_W + PRG_WIN_AW,
  localparam int CHR_AW      = CHR_BANK_W + CHR_WIN_AW
) (
  input  logic               clk,
  input  logic               rst,
  input  regStrobe_t         strobe,
  input  logic [DATA_W-1:0]  cpuData,
  input  logic [15:0]        cpuAddr,
  input  logic [13:0]        ppuAddr,
  output logic [DATA_W-1:0]  bankRegA,
  output logic [DATA_W-1:0]  bankRegB,
  output logic [MODE_W-1:0]  modeReg,
  output logic [PRG_AW-1:0]  prgRomAddr,
  output logic [CHR_AW-1:0]  chrRomAddr,
  output logic               ciramA10
);
  localparam int MIRROR_BIT = OUTER_W;
  localparam int WIDE_BIT   = OUTER_W + 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      bankRegA <= '0;
      bankRegB <= '0;
      modeReg  <= '0;
    end else begin
      if (strobe.loadBankA) bankRegA <= cpuData;
      if (strobe.loadBankB) bankRegB <= cpuData;
      if (strobe.loadMode)  modeReg  <= cpuData[MODE_W-1:0];
    end
  end

  logic [OUTER_W-1:0]     group;
  logic [PRG_INNER_W-1:0] loInner, hiInner;
  logic [PRG_BANK_W-1:0]  prgBank;
  assign group = modeReg[OUTER_W-1:0];

  always_comb begin
    if (modeReg[WIDE_BIT]) begin
      loInner = {bankRegA[PRG_INNER_W-1:1], 1'b0};
      hiInner = {bankRegA[PRG_INNER_W-1:1], 1'b1};
    end else begin
      loInner = bankRegA[PRG_INNER_W-1:0];
      hiInner = '1;
    end
    prgBank = {group, (cpuAddr[PRG_WIN_AW] ? hiInner : loInner)};
  end

  assign prgRomAddr = {prgBank, cpuAddr[PRG_WIN_AW-1:0]};

  logic [CHR_BANK_W-1:0] chrBankWin [2];
  for (genvar w = 0; w < 2; w++) begin : gChrWin
    logic [DATA_W-1:0] src;
    assign src = (w == 0) ? bankRegA : bankRegB;
    assign chrBankWin[w] = {group, src[DATA_W-1:PRG_INNER_W]};
  end

  assign chrRomAddr = {chrBankWin[ppuAddr[CHR_WIN_AW]], ppuAddr[CHR_WIN_AW-1:0]};
  assign ciramA10   = modeReg[MIRROR_BIT] ? ppuAddr[11] : ppuAddr[10];
endmodule

// File: rtl/multicart_bank_mapper.sv
module multicart_bank_mapper
  import mcmap_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OUTER_W     = 2,
  parameter int PRG_INNER_W = 3,
  parameter int PRG_WIN_AW  = 14,
  parameter int CHR_WIN_AW  = 12,
  localparam int MODE_W     = OUTER_W + 2,
  localparam int PRG_AW     = OUTER_W + PRG_INNER_W + PRG_WIN_AW,
  localparam int CHR_AW     = OUTER_W + (DATA_W - PRG_INNER_W) + CHR_WIN_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cpuAddr,
  input  logic [DATA_W-1:0] cpuData,
  input  logic              cpuWrite,
  input  logic [13:0]       ppuAddr,
  output logic [PRG_AW-1:0] prgRomAddr,
  output logic [CHR_AW-1:0] chrRomAddr,
  output logic              ciramA10
);
  regStrobe_t        strobe;
  logic [DATA_W-1:0] bankRegA, bankRegB;
  logic [MODE_W-1:0] modeReg;

  mcmap_ctrl uCtrl (
    .cpuAddr (cpuAddr),
    .cpuWrite(cpuWrite),
    .strobe  (strobe)
  );

  mcmap_datapath #(
    .DATA_W     (DATA_W),
    .OUTER_W    (OUTER_W),
    .PRG_INNER_W(PRG_INNER_W),
    .PRG_WIN_AW (PRG_WIN_AW),
    .CHR_WIN_AW (CHR_WIN_AW)
  ) uData (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .cpuData   (cpuData),
    .cpuAddr   (cpuAddr),
    .ppuAddr   (ppuAddr),
    .bankRegA  (bankRegA),
    .bankRegB  (bankRegB),
    .modeReg   (modeReg),
    .prgRomAddr(prgRomAddr),
    .chrRomAddr(chrRomAddr),
    .ciramA10  (ciramA10)
  );
endmodule

// File: rtl/mcmap_checker.sv
module mcmap_checker #(
  parameter int DATA_W      = 8,
  parameter int OUTER_W     = 2,
  parameter int PRG_INNER_W = 3,
  parameter int PRG_WIN_AW  = 14,
  parameter int CHR_WIN_AW  = 12,
  localparam int MODE_W     = OUTER_W + 2,
  localparam int PRG_AW     = OUTER_W + PRG_INNER_W + PRG_WIN_AW,
  localparam int CHR_AW     = OUTER_W + (DATA_W - PRG_INNER_W) + CHR_WIN_AW
) (
  input logic              clk,
  input logic              rst,
  input logic [15:0]       cpuAddr,
  input logic [DATA_W-1:0] cpuData,
  input logic              cpuWrite,
  input logic [PRG_AW-1:0] prgRomAddr,
  input logic [CHR_AW-1:0] chrRomAddr,
  input logic [DATA_W-1:0] bankRegA,
  input logic [DATA_W-1:0] bankRegB,
  input logic [MODE_W-1:0] modeReg
);
  logic wrA, wrB, wrM, wrDead;
  assign wrA    = cpuWrite && cpuAddr[15:13] == 3'b101;
  assign wrB    = cpuWrite && cpuAddr[15:13] == 3'b110;
  assign wrM    = cpuWrite && cpuAddr[15:13] == 3'b111;
  assign wrDead = cpuWrite && (cpuAddr[15:13] == 3'b100 || !cpuAddr[15]);

  assert_load_a_R1: assert property (@(posedge clk) disable iff (rst)
    wrA |=> bankRegA == $past(cpuData));
  assert_load_b_R1: assert property (@(posedge clk) disable iff (rst)
    wrB |=> bankRegB == $past(cpuData));
  assert_dead_write_R2: assert property (@(posedge clk) disable iff (rst)
    wrDead |=> ($stable(bankRegA) && $stable(bankRegB) && $stable(modeReg)));
  assert_mode_nibble_R3: assert property (@(posedge clk) disable iff (rst)
    wrM |=> modeReg == $past(cpuData[MODE_W-1:0]));
  assert_fixed_last_R4: assert property (@(posedge clk) disable iff (rst)
    (!modeReg[OUTER_W+1] && cpuAddr[PRG_WIN_AW])
      |-> prgRomAddr[PRG_WIN_AW +: PRG_INNER_W] == '1);
  assert_pair_parity_R5: assert property (@(posedge clk) disable iff (rst)
    modeReg[OUTER_W+1] |-> prgRomAddr[PRG_WIN_AW] == cpuAddr[PRG_WIN_AW]);
  assert_group_scale_R6: assert property (@(posedge clk) disable iff (rst)
    (prgRomAddr[PRG_AW-1 -: OUTER_W] == modeReg[OUTER_W-1:0]) &&
    (chrRomAddr[CHR_AW-1 -: OUTER_W] == modeReg[OUTER_W-1:0]));
  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (bankRegA == '0 && bankRegB == '0 && modeReg == '0));
endmodule

bind multicart_bank_mapper mcmap_checker #(
  .DATA_W     (DATA_W),
  .OUTER_W    (OUTER_W),
  .PRG_INNER_W(PRG_INNER_W),
  .PRG_WIN_AW (PRG_WIN_AW),
  .CHR_WIN_AW (CHR_WIN_AW)
) uChecker (
  .clk       (clk),
  .rst       (rst),
  .cpuAddr   (cpuAddr),
  .cpuData   (cpuData),
  .cpuWrite  (cpuWrite),
  .prgRomAddr(prgRomAddr),
  .chrRomAddr(chrRomAddr),
  .bankRegA  (bankRegA),
  .bankRegB  (bankRegB),
  .modeReg   (modeReg)
);

// File: tb/tb_multicart_bank_mapper.sv
module tb_multicart_bank_mapper;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] cpuAddr;
  logic [7:0]  cpuData;
  logic        cpuWrite;
  logic [13:0] ppuAddr;
  logic [18:0] prgRomAddr;
  logic [18:0] chrRomAddr;
  logic        ciramA10;

  int checks = 0;
  int errors = 0;
  logic [7:0] mA, mB;
  logic [3:0] mMode;

  always #5 clk = ~clk;

  multicart_bank_mapper dut (
    .clk(clk), .rst(rst), .cpuAddr(cpuAddr), .cpuData(cpuData),
    .cpuWrite(cpuWrite), .ppuAddr(ppuAddr), .prgRomAddr(prgRomAddr),
    .chrRomAddr(chrRomAddr), .ciramA10(ciramA10)
  );

  function automatic logic [18:0] expPrg(logic [15:0] a);
    logic [2:0] inner;
    if (mMode[3]) inner = {mA[2:1], a[14]};
    else          inner = a[14] ? 3'b111 : mA[2:0];
    return {mMode[1:0], inner, a[13:0]};
  endfunction

  function automatic logic [18:0] expChr(logic [13:0] p);
    logic [4:0] hi5;
    hi5 = p[12] ? mB[7:3] : mA[7:3];
    return {mMode[1:0], hi5, p[11:0]};
  endfunction

  function automatic logic expA10(logic [13:0] p);
    return mMode[2] ? p[11] : p[10];
  endfunction

  task automatic checkVal(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doWrite(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuData = d; cpuWrite = 1'b1;
    @(negedge clk);
    cpuWrite = 1'b0;
    if (a[15] && a[14:13] != 2'b00) begin
      case (a[14:13])
        2'b01: mA = d;
        2'b10: mB = d;
        default: mMode = d[3:0];
      endcase
    end
  endtask

  task automatic probe(logic [15:0] a, logic [13:0] p, string req);
    cpuAddr = a; ppuAddr = p;
    #1;
    checkVal({req, " prg R10"}, 32'(prgRomAddr), 32'(expPrg(a)));
    checkVal({req, " chr R7"}, 32'(chrRomAddr), 32'(expChr(p)));
    checkVal({req, " mirror R8"}, 32'(ciramA10), 32'(expA10(p)));
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seedDummy;
    seedDummy = $urandom(32'h1c0ffee);
    cpuAddr = 16'h0; cpuData = 8'h0; cpuWrite = 1'b0; ppuAddr = 14'h0;
    mA = 8'h0; mB = 8'h0; mMode = 4'h0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R9: reset mapping
    probe(16'h8000, 14'h0000, "R9");
    checkVal("R9 lo window bank", 32'(prgRomAddr[18:14]), 32'd0);
    probe(16'hC000, 14'h1000, "R9");
    checkVal("R9 hi window bank", 32'(prgRomAddr[18:14]), 32'd7);
    checkVal("R9 chr bank", 32'(chrRomAddr[18:12]), 32'd0);
    checkVal("R9 vertical", 32'(ciramA10), 32'(ppuAddr[10]));

    // R1 / R4: 16 KB mode select
    doWrite(16'hA123, 8'h2D);
    probe(16'h8000, 14'h0000, "R4");
    checkVal("R4 lo bank 5", 32'(prgRomAddr[18:14]), 32'd5);
    probe(16'hC000, 14'h1000, "R4");
    checkVal("R4 hi fixed 7", 32'(prgRomAddr[18:14]), 32'd7);
    checkVal("R1 chr from A", 32'(chrRomAddr[18:12]), 32'd0);
    doWrite(16'hDFFF, 8'h48);
    probe(16'h8000, 14'h1abc, "R1");
    checkVal("R1 chr from B", 32'(chrRomAddr[18:12]), 32'd9);

    // R2: dead region and CPU low half
    doWrite(16'h8000, 8'hFF);
    doWrite(16'h9FFF, 8'hFF);
    doWrite(16'h6000, 8'hFF);
    probe(16'h8000, 14'h0000, "R2");
    checkVal("R2 lo bank kept", 32'(prgRomAddr[18:14]), 32'd5);
    checkVal("R2 chr kept", 32'(chrRomAddr[18:12]), 32'd5);

    // R3: upper nibble of mode discarded
    doWrite(16'hE000, 8'hF4);
    probe(16'h8000, 14'h0800, "R3");
    checkVal("R3 group zero", 32'(prgRomAddr[18:17]), 32'd0);
    checkVal("R3 horizontal", 32'(ciramA10), 32'd1);

    // R5: pair mode ignores bit 0
    doWrite(16'hE000, 8'h08);
    doWrite(16'hA000, 8'h05);
    probe(16'h8000, 14'h0000, "R5");
    checkVal("R5 even bank", 32'(prgRomAddr[18:14]), 32'd4);
    probe(16'hC000, 14'h0000, "R5");
    checkVal("R5 odd bank", 32'(prgRomAddr[18:14]), 32'd5);

    // R6: group scaling
    doWrite(16'hE000, 8'h03);
    doWrite(16'hA000, 8'h00);
    probe(16'h8000, 14'h0000, "R6");
    checkVal("R6 prg group 3", 32'(prgRomAddr[18:14]), 32'd24);
    checkVal("R6 chr group 3", 32'(chrRomAddr[18:12]), 32'd96);
    probe(16'hC000, 14'h0000, "R6");
    checkVal("R6 prg last", 32'(prgRomAddr[18:14]), 32'd31);

    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic [15:0] a;
      a = 16'($urandom);
      if ((i % 4) == 0) a[15:13] = 3'b111;
      doWrite(a, 8'($urandom));
      for (int k = 0; k < 3; k++) begin
        logic [15:0] ra;
        ra = 16'($urandom) | 16'h8000;
        probe(ra, 14'($urandom), mMode[3] ? "R5 rand" : "R4 rand");
      end
    end

    // R9: reset after activity
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    mA = 8'h0; mB = 8'h0; mMode = 4'h0;
    probe(16'hC000, 14'h1c00, "R9 post");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule